// File: doc/BRIEF.md
# 9/7 Lifting Wavelet Core (1-D, forward)

The block performs a one-dimensional forward 9/7 biorthogonal wavelet transform on a stream of signed 16-bit samples, using four lifting steps followed by a scaling step rather than a convolution filter bank. Samples arrive one per clock at most, each qualified by a strobe. The block pairs each even-position sample with the odd-position sample after it. The pairs pass through a predict step, an update step, a second predict step and a second update step, and each result is then normalised. For every input pair the block delivers one low-pass and one high-pass coefficient, each with its own strobe.

The stream is cut into rows of a fixed number of pairs, set by a parameter. At each row end the block mirrors the missing neighbour, so every row is transformed on its own. Each step multiplies by a signed Q2.14 constant and floors the product back to the working width. The working width is the sample width plus four guard bits. No stall is ever needed: a step that has to look one pair ahead holds the current item until the next one arrives. At a row end it sends out the held item on the following cycle.

Top module: `dwt97_lift_core`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, and after its release until the first coefficient pair is ready, `lo_valid` and `hi_valid` stay low.
- R2: Only strobed samples are counted. After reset, strobed samples alternate even, odd, even, and so on. Pair k of a row is samples 2k (even, s0[k]) and 2k+1 (odd, d0[k]). A row has ROW_PAIRS pairs, and the next strobed sample starts a new row.
- R3: With P(c,v) = floor(c*v / 2^14), the constants are a = -25987, b = -868, g = 14466 and e = 7266. The steps are d1[k] = d0[k] + P(a, s0[k]+s0[k+1]); then s1[k] = s0[k] + P(b, d1[k-1]+d1[k]); then d2[k] = d1[k] + P(g, s1[k]+s1[k+1]); then s2[k] = s1[k] + P(e, d2[k-1]+d2[k]).
- R4: In both predict steps, the pair at the last index of a row uses its own even value in place of the missing right neighbour.
- R5: In both update steps, index 0 of a row uses its own detail value in place of the missing left neighbour.
- R6: The outputs are lo = P(14252, s2[k]) and hi = P(18835, d2[k]), as two's complement values 20 bits wide (DATA_W+GUARD_W).
- R7: For index k at most ROW_PAIRS-3, the pair for k is valid 5 clock edges after the edge that samples the odd sample of pair k+2.
- R8: Counted from the edge that samples the last odd sample of a row, index ROW_PAIRS-2 is valid 6 edges later and index ROW_PAIRS-1 is valid 7 edges later. This holds even when no further input arrives.
- R9: Idle cycles between strobed samples do not change any coefficient value. The timing rules of R7 and R8 still count from the edges that sampled the samples.
- R10: `lo_valid` and `hi_valid` are high together for one cycle per coefficient pair. Each row gives exactly ROW_PAIRS pairs, in index order, and nothing else is emitted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe qualifying `in_sample` |
| in_sample | input | 16 | Signed input sample |
| lo_valid | output | 1 | Low-pass coefficient strobe |
| lo_coef | output | 20 | Signed low-pass coefficient |
| hi_valid | output | 1 | High-pass coefficient strobe |
| hi_coef | output | 20 | Signed high-pass coefficient |

## Verification
Before any stimulus is applied, the bench fixes the edge at which every input sample is sampled. From those edges it derives the cycle in which each coefficient pair is due. Interior indices are due 5 edges after the odd sample of the pair two ahead. The last two indices of a row are due 6 and 7 edges after the row's final odd sample. On every falling edge the bench compares the strobes and both coefficients with a behavioural integer model of the lifting steps. A pair that arrives early, arrives late or is missing is reported in the same cycle. Rows with idle gaps, back-to-back rows and a final row followed by silence cover the flush path at row ends.

// File: rtl/dwt97_pkg.sv
package dwt97_pkg;

    // Fixed-point format of every lifting and scaling constant (Q2.14)
    localparam int CF_W    = 16;
    localparam int CF_FRAC = 14;

    localparam logic signed [CF_W-1:0] C_ALPHA = -16'sd25987;
    localparam logic signed [CF_W-1:0] C_BETA  = -16'sd868;
    localparam logic signed [CF_W-1:0] C_GAMMA =  16'sd14466;
    localparam logic signed [CF_W-1:0] C_DELTA =  16'sd7266;
    localparam logic signed [CF_W-1:0] C_KSCL  =  16'sd18835;
    localparam logic signed [CF_W-1:0] C_INV_K =  16'sd14252;

    localparam int N_STEPS = 4;
    localparam logic signed [CF_W-1:0] LIFT_COEF [N_STEPS] =
        '{C_ALPHA, C_BETA, C_GAMMA, C_DELTA};

    typedef enum logic {PH_EVEN, PH_ODD} split_phase_e;
    typedef enum logic {STEP_PREDICT, STEP_UPDATE} step_kind_e;

    // Steps alternate: predict, update, predict, update
    function automatic step_kind_e kind_of(input int idx);
        return (idx % 2 == 0) ? STEP_PREDICT : STEP_UPDATE;
    endfunction

endpackage

// File: rtl/dwt97_split.sv
module dwt97_split
    import dwt97_pkg::*;
#(
    parameter int DW        = 16,
    parameter int W         = 20,
    parameter int ROW_PAIRS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic signed [DW-1:0] in_data,
    output logic                out_vld,
    output logic signed [W-1:0] out_even,
    output logic signed [W-1:0] out_odd,
    output logic                out_last
);
    localparam int CNT_W = (ROW_PAIRS > 1) ? $clog2(ROW_PAIRS) : 1;

    split_phase_e        phase;
    logic signed [W-1:0] even_q;
    logic [CNT_W-1:0]    pair_cnt;
    logic                row_end;

    assign row_end = (pair_cnt == CNT_W'(ROW_PAIRS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_EVEN;
            pair_cnt <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= 1'b0;
            if (in_vld) begin
                if (phase == PH_EVEN) begin
                    even_q <= W'(in_data);
                    phase  <= PH_ODD;
                end else begin
                    out_vld  <= 1'b1;
                    out_even <= even_q;
                    out_odd  <= W'(in_data);
                    out_last <= row_end;
                    pair_cnt <= row_end ? '0 : pair_cnt + 1'b1;
                    phase    <= PH_EVEN;
                end
            end
        end
    end

    // R2: a pair is only formed on an edge that took a strobed sample
    a_r2_pair_needs_sample: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $past(in_vld));

endmodule

// File: rtl/dwt97_lift_step.sv
module dwt97_lift_step
    import dwt97_pkg::*;
#(
    parameter int                      W    = 20,
    parameter step_kind_e              KIND = STEP_PREDICT,
    parameter logic signed [CF_W-1:0]  COEF = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_even,
    input  logic signed [W-1:0] in_odd,
    input  logic                in_last,
    output logic                out_vld,
    output logic signed [W-1:0] out_even,
    output logic signed [W-1:0] out_odd,
    output logic                out_last
);
    localparam int PW = W + 1 + CF_W;

    generate
        if (KIND == STEP_PREDICT) begin : g_pred
            // Holds one item until its right-hand even neighbour is known
            logic                h_vld, h_last;
            logic signed [W-1:0] h_e, h_o, right, corr;
            logic signed [W:0]   sum;
            logic signed [PW-1:0] prod;
            logic                emit;

            always_comb begin
                emit  = h_vld && (in_vld || h_last);
                right = h_last ? h_e : in_even;
                sum   = (W+1)'(h_e) + (W+1)'(right);
                prod  = PW'(sum) * PW'(COEF);
                corr  = W'(prod >>> CF_FRAC);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    h_vld   <= 1'b0;
                    h_last  <= 1'b0;
                    out_vld <= 1'b0;
                end else begin
                    out_vld <= emit;
                    if (emit) begin
                        out_odd  <= h_o + corr;
                        out_even <= h_e;
                        out_last <= h_last;
                    end
                    if (in_vld) begin
                        h_vld  <= 1'b1;
                        h_e    <= in_even;
                        h_o    <= in_odd;
                        h_last <= in_last;
                    end else if (emit) begin
                        h_vld <= 1'b0;
                    end
                end
            end

            // R8: a held row-end item leaves on the very next edge
            a_r8_flush_emits: assert property (@(posedge clk) disable iff (rst)
                (h_vld && h_last) |=> (out_vld && out_last));

            // R8: upstream never delivers a new item while a row end is pending
            a_r8_no_overlap: assert property (@(posedge clk) disable iff (rst)
                in_vld |-> !(h_vld && h_last));

            // R7: an output needs a held item from the previous cycle
            a_r7_emit_needs_context: assert property (@(posedge clk) disable iff (rst)
                out_vld |-> $past(h_vld));

        end else begin : g_upd
            // Keeps the previous detail as left neighbour
            logic                first_q;
            logic signed [W-1:0] prev_d, left, corr;
            logic signed [W:0]   sum;
            logic signed [PW-1:0] prod;

            always_comb begin
                left = first_q ? in_odd : prev_d;
                sum  = (W+1)'(left) + (W+1)'(in_odd);
                prod = PW'(sum) * PW'(COEF);
                corr = W'(prod >>> CF_FRAC);
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    first_q <= 1'b1;
                    out_vld <= 1'b0;
                end else begin
                    out_vld <= in_vld;
                    if (in_vld) begin
                        out_even <= in_even + corr;
                        out_odd  <= in_odd;
                        out_last <= in_last;
                        prev_d   <= in_odd;
                        first_q  <= in_last;
                    end
                end
            end

            // R10: a row-end result is never followed directly by another
            a_r10_row_end_gap: assert property (@(posedge clk) disable iff (rst)
                (out_vld && out_last) |=> !out_vld);
        end
    endgenerate

endmodule

// File: rtl/dwt97_scale.sv
module dwt97_scale
    import dwt97_pkg::*;
#(
    parameter int W = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_even,
    input  logic signed [W-1:0] in_odd,
    input  logic                in_last,
    output logic                out_vld,
    output logic signed [W-1:0] out_lo,
    output logic signed [W-1:0] out_hi
);
    localparam int PW = W + CF_W;

    logic signed [PW-1:0] p_lo, p_hi;

    always_comb begin
        p_lo = PW'(in_even) * PW'(C_INV_K);
        p_hi = PW'(in_odd)  * PW'(C_KSCL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_lo <= W'(p_lo >>> CF_FRAC);
                out_hi <= W'(p_hi >>> CF_FRAC);
            end
        end
    end

    // R6: positive scale factors keep the sign of each coefficient
    a_r6_lo_sign: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (out_lo[W-1] == $past(in_even[W-1])));
    a_r6_hi_sign: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (out_hi[W-1] == $past(in_odd[W-1])));

    // R8: the last item of a row is never directly followed by another
    a_r8_last_then_idle: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_last) |=> !in_vld);

endmodule

// File: rtl/dwt97_lift_core.sv
module dwt97_lift_core
    import dwt97_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int GUARD_W   = 4,
    parameter int ROW_PAIRS = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             in_valid,
    input  logic signed [DATA_W-1:0]         in_sample,
    output logic                             lo_valid,
    output logic signed [DATA_W+GUARD_W-1:0] lo_coef,
    output logic                             hi_valid,
    output logic signed [DATA_W+GUARD_W-1:0] hi_coef
);
    localparam int W = DATA_W + GUARD_W;

    logic                st_vld  [N_STEPS+1];
    logic signed [W-1:0] st_even [N_STEPS+1];
    logic signed [W-1:0] st_odd  [N_STEPS+1];
    logic                st_last [N_STEPS+1];
    logic                sc_vld;

    dwt97_split #(.DW(DATA_W), .W(W), .ROW_PAIRS(ROW_PAIRS)) u_split (
        .clk      (clk),
        .rst      (rst),
        .in_vld   (in_valid),
        .in_data  (in_sample),
        .out_vld  (st_vld[0]),
        .out_even (st_even[0]),
        .out_odd  (st_odd[0]),
        .out_last (st_last[0])
    );

    generate
        for (genvar g = 0; g < N_STEPS; g++) begin : g_step
            dwt97_lift_step #(
                .W    (W),
                .KIND (kind_of(g)),
                .COEF (LIFT_COEF[g])
            ) u_step (
                .clk      (clk),
                .rst      (rst),
                .in_vld   (st_vld[g]),
                .in_even  (st_even[g]),
                .in_odd   (st_odd[g]),
                .in_last  (st_last[g]),
                .out_vld  (st_vld[g+1]),
                .out_even (st_even[g+1]),
                .out_odd  (st_odd[g+1]),
                .out_last (st_last[g+1])
            );
        end
    endgenerate

    dwt97_scale #(.W(W)) u_scale (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (st_vld[N_STEPS]),
        .in_even (st_even[N_STEPS]),
        .in_odd  (st_odd[N_STEPS]),
        .in_last (st_last[N_STEPS]),
        .out_vld (sc_vld),
        .out_lo  (lo_coef),
        .out_hi  (hi_coef)
    );

    assign lo_valid = sc_vld;
    assign hi_valid = sc_vld;

endmodule

// File: tb/dwt97_lift_core_test.sv
module dwt97_lift_core_test;
    localparam int DW = 16;
    localparam int GW = 4;
    localparam int W  = DW + GW;
    localparam int M  = 8;
    localparam int N  = 2 * M;
    localparam int NROWS = 6;

    localparam longint KA = -25987, KB = -868, KG = 14466, KD = 7266;
    localparam longint KS = 18835, KI = 14252;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst, in_valid;
    logic signed [DW-1:0] in_sample;
    logic                 lo_valid, hi_valid;
    logic signed [W-1:0]  lo_coef, hi_coef;

    dwt97_lift_core #(.DATA_W(DW), .GUARD_W(GW), .ROW_PAIRS(M)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .lo_valid(lo_valid), .lo_coef(lo_coef),
        .hi_valid(hi_valid), .hi_coef(hi_coef)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int nchk = 0, nfail = 0, nout = 0;

    int                   s_edge[$];
    logic signed [DW-1:0] s_dat[$];
    int                   e_edge[$];
    longint               e_lo[$], e_hi[$];
    string                e_vtag[$], e_ttag[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic longint lm(input longint c, input longint v);
        return (c * v) >>> 14;
    endfunction

    // Behavioural model of one row: lifting with mirrored ends, then timing
    task automatic model_row(input longint x[N], input int t[M], input bit gapped);
        longint s0[M], d0[M], d1[M], s1[M], d2[M], s2[M];
        for (int k = 0; k < M; k++) begin
            s0[k] = x[2*k];
            d0[k] = x[2*k+1];
        end
        for (int k = 0; k < M; k++)
            d1[k] = d0[k] + lm(KA, s0[k] + s0[(k == M-1) ? k : k+1]);
        for (int k = 0; k < M; k++)
            s1[k] = s0[k] + lm(KB, d1[(k == 0) ? 0 : k-1] + d1[k]);
        for (int k = 0; k < M; k++)
            d2[k] = d1[k] + lm(KG, s1[k] + s1[(k == M-1) ? k : k+1]);
        for (int k = 0; k < M; k++)
            s2[k] = s1[k] + lm(KD, d2[(k == 0) ? 0 : k-1] + d2[k]);
        for (int k = 0; k < M; k++) begin
            string vt, tt;
            e_lo.push_back(lm(KI, s2[k]));
            e_hi.push_back(lm(KS, d2[k]));
            if (k <= M-3)      e_edge.push_back(t[k+2] + 5);
            else if (k == M-2) e_edge.push_back(t[M-1] + 6);
            else               e_edge.push_back(t[M-1] + 7);
            vt = (k == 0) ? "R5,R3,R6" : ((k >= M-2) ? "R4,R3,R6" : "R2,R3,R6");
            tt = (k <= M-3) ? "R7" : "R8";
            if (gapped) begin
                vt = {vt, ",R9"};
                tt = {tt, ",R9"};
            end
            e_vtag.push_back(vt);
            e_ttag.push_back(tt);
        end
    endtask

    // Whole stimulus is scheduled up front so every due cycle is known early
    task automatic build_schedule();
        int     nxt;
        int     seed;
        longint xs[N];
        int     ts[M];
        nxt  = cyc + 3;
        seed = 32'h1234_5678;
        for (int r = 0; r < NROWS; r++) begin
            for (int k = 0; k < N; k++) begin
                longint v;
                int     gap;
                case (r)
                    0: v = k * 100 - 700;
                    1: v = 1234;
                    2: v = (k % 2 == 0) ? 32767 : -32768;
                    3, 4: begin
                        seed = seed * 1664525 + 1013904223;
                        v = longint'($signed(seed[23:8]));
                    end
                    default: v = k * k * 137 - 9000;
                endcase
                xs[k] = v;
                if (k % 2 == 1) ts[k/2] = nxt;
                s_edge.push_back(nxt);
                s_dat.push_back(DW'(v));
                gap = (r == 3) ? (k % 3) : 0;
                nxt = nxt + 1 + gap;
            end
            if (r == 1) nxt = nxt + 5;
            model_row(xs, ts, r == 3);
        end
    endtask

    // Output scoreboard, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (lo_valid || hi_valid) begin
                check(lo_valid == hi_valid, "R10", "strobe pairing", lo_valid, hi_valid);
                if (e_edge.size() == 0) begin
                    check(1'b0, "R10", "unexpected output cycle", cyc, -1);
                end else begin
                    check(cyc == e_edge[0], e_ttag[0], "output cycle", cyc, e_edge[0]);
                    check(lo_coef == e_lo[0], e_vtag[0], "low-pass value", lo_coef, e_lo[0]);
                    check(hi_coef == e_hi[0], e_vtag[0], "high-pass value", hi_coef, e_hi[0]);
                    void'(e_edge.pop_front()); void'(e_lo.pop_front()); void'(e_hi.pop_front());
                    void'(e_vtag.pop_front()); void'(e_ttag.pop_front());
                    nout++;
                end
            end else if (e_edge.size() > 0 && e_edge[0] <= cyc) begin
                check(1'b0, e_ttag[0], "missing output", cyc, e_edge[0]);
                void'(e_edge.pop_front()); void'(e_lo.pop_front()); void'(e_hi.pop_front());
                void'(e_vtag.pop_front()); void'(e_ttag.pop_front());
            end
        end
    end

    initial begin
        int guard;
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_sample = '0;
        repeat (3) @(negedge clk);
        check(!lo_valid && !hi_valid, "R1", "strobes during reset", lo_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!lo_valid && !hi_valid, "R1", "strobes after release", hi_valid, 0);

        build_schedule();
        while (s_edge.size() > 0) begin
            if (s_edge[0] == cyc + 1) begin
                in_valid  = 1'b1;
                in_sample = s_dat[0];
                void'(s_edge.pop_front());
                void'(s_dat.pop_front());
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;

        // Watchdog: pending outputs must drain with the input idle (R8)
        guard = 0;
        while (e_edge.size() > 0 && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        if (e_edge.size() > 0)
            check(1'b0, "R8", "watchdog expired, outputs pending", e_edge.size(), 0);
        repeat (12) @(negedge clk);
        check(nout == NROWS * M, "R10", "coefficient pairs emitted", nout, NROWS * M);
        check(!lo_valid && !hi_valid, "R10", "idle strobes after drain", lo_valid, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule